// File: doc/BRIEF.md
# Descriptor Cache Flush Controller

This block carries out flush commands against a small descriptor cache and keeps four reusable address-blocking slots. A command arrives already decoded as two 32-bit payload words over a valid/ready handshake; one command runs at a time. The block checks the command for errors and frees or claims blocking slots. When asked, it first has an external queue engine forward every packet held for the descriptor's queue. It then issues a single-line or whole-cache flush request, waits for completion and pulses a status code.

A second command kind, unblock, frees one slot or releases the global lock that a whole-cache flush leaves in place. A combinational lookup port tells the cache's access path whether an address is blocked at present. The block contains neither the cache storage nor the queue engine.

Top module: `desc_flush_ctrl`

## Requirements
- R1: The descriptor address is 40 bits: bits 31:0 come from `cmd_word0` and bits 39:32 from `cmd_word1[7:0]`. `flush_addr` and `fwd_addr` present this address for the whole time the matching request is high.
- R2: On a flush command, a nonzero `cmd_word1[31:15]` rejects the command with status code 2 (illegal field). No request is raised and no slot or lock changes.
- R3: Release-slot is `cmd_word1[9]` and the slot index is `cmd_word1[11:10]`. If release-slot is set and the selected slot is free, the command returns code 1 (resource error) and does no flush.
- R4: Block-after-flush is `cmd_word1[13]`. If it selects an occupied slot and release-slot is clear, the command returns code 1, does no flush and leaves that slot as it was.
- R5: With both release-slot and block-after-flush set on an occupied slot, the slot is freed first. After the flush completes it holds the new address, so the old address is no longer blocked.
- R6: When forward-packets (`cmd_word1[8]`) is set on a line flush, `fwd_req` stays high until `fwd_done`, and `flush_req` rises only after that.
- R7: A line flush drives `flush_all`=0, and `flush_keep` follows `cmd_word1[12]`, which means write out without invalidating.
- R8: When flush-entire (`cmd_word1[14]`) is set, all other control bits are ignored: there is no forward request, no slot check and no slot change. `flush_all`=1, and after completion every lookup reports blocked.
- R9: An unblock command (`cmd_unblock`=1) with `cmd_word1[14]`=0 frees slot `cmd_word1[11:10]` and returns code 0. If that slot is already free it returns code 1.
- R10: An unblock command with `cmd_word1[14]`=1 clears the global lock and returns code 0. If the cache is not locked it returns code 1.
- R11: `lk_blocked` is high exactly when the cache is locked or an occupied slot equals `lk_addr` in all 40 bits.
- R12: `sts_valid` is a single-cycle pulse carrying code 0 (success), 1 (resource error) or 2 (illegal field). `cmd_ready` is low while a command is in progress.
- R13: After reset, `cmd_ready`=1, no request or status is raised and nothing is blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command accepted this cycle |
| cmd_unblock | input | 1 | 1 = unblock command, 0 = flush command |
| cmd_word0 | input | 32 | Address bits 31:0 |
| cmd_word1 | input | 32 | Address bits 39:32 and control bits |
| fwd_req | output | 1 | Request to forward queued packets |
| fwd_addr | output | 40 | Descriptor address for the forward |
| fwd_done | input | 1 | Forwarding finished |
| flush_req | output | 1 | Flush request to the cache |
| flush_addr | output | 40 | Line address to flush |
| flush_all | output | 1 | Flush the whole cache |
| flush_keep | output | 1 | Write out without invalidating |
| flush_done | input | 1 | Flush finished |
| sts_valid | output | 1 | Status pulse |
| sts_code | output | 2 | 0 success, 1 resource error, 2 illegal field |
| lk_addr | input | 40 | Access address to look up |
| lk_blocked | output | 1 | Access address is blocked |

## Verification
The bench runs a sequence of commands in which slot state carries over from one command to the next. The sequence includes a release of a free slot, a block into a taken slot and a release-and-reblock of the same slot. A design that skipped the ordering would flush when it should refuse, or would keep blocking the old address. A whole-cache flush is sent with release, forward and index bits all set. A design that did not ignore them would report an error or raise a forward request. The lookup is probed with an address that differs only in bit 39, which catches a truncated compare. The bench also checks that a lock clears only through an unblock of the whole-cache type.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
    localparam int ADDR_W     = 40;
    localparam int ADDR_HI_LSB = 0;
    localparam int BIT_FWD    = 8;
    localparam int BIT_REL    = 9;
    localparam int IDX_LSB    = 10;
    localparam int BIT_KEEP   = 12;
    localparam int BIT_BLK    = 13;
    localparam int BIT_ALL    = 14;
    localparam int RSVD_LSB   = 15;

    typedef enum logic [1:0] {
        STS_OK  = 2'd0,
        STS_RES = 2'd1,
        STS_ILL = 2'd2
    } sts_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FWD   = 2'd1,
        ST_FLUSH = 2'd2
    } st_e;
endpackage

// File: rtl/dcf_cmd_decode.sv
module dcf_cmd_decode
    import dcf_pkg::*;
#(
    parameter int SLOT_W = 2
) (
    input  logic [31:0]         word0,
    input  logic [31:0]         word1,
    output logic [ADDR_W-1:0]   addr,
    output logic                fwd,
    output logic                rel,
    output logic [SLOT_W-1:0]   idx,
    output logic                keep,
    output logic                blk,
    output logic                all,
    output logic                rsvd_bad
);
    localparam int HI_W = ADDR_W - 32;

    always_comb begin
        addr     = {word1[ADDR_HI_LSB +: HI_W], word0};
        fwd      = word1[BIT_FWD];
        rel      = word1[BIT_REL];
        idx      = word1[IDX_LSB +: SLOT_W];
        keep     = word1[BIT_KEEP];
        blk      = word1[BIT_BLK];
        all      = word1[BIT_ALL];
        rsvd_bad = |word1[31:RSVD_LSB];
    end
endmodule

// File: rtl/dcf_slot_table.sv
module dcf_slot_table
    import dcf_pkg::*;
#(
    parameter int NSLOT  = 4,
    parameter int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr_en,
    input  logic [SLOT_W-1:0]   clr_idx,
    input  logic                set_en,
    input  logic [SLOT_W-1:0]   set_idx,
    input  logic [ADDR_W-1:0]   set_addr,
    input  logic [ADDR_W-1:0]   lk_addr,
    output logic [NSLOT-1:0]    occ,
    output logic                lk_hit
);
    typedef struct packed {
        logic [NSLOT-1:0]             occ;
        logic [NSLOT-1:0][ADDR_W-1:0] addr;
    } tbl_t;

    tbl_t tbl_d, tbl_q;
    logic [NSLOT-1:0] match;

    always_comb begin
        tbl_d = tbl_q;
        if (clr_en) tbl_d.occ[clr_idx] = 1'b0;
        if (set_en) begin
            tbl_d.occ[set_idx]  = 1'b1;
            tbl_d.addr[set_idx] = set_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    for (genvar g = 0; g < NSLOT; g++) begin : g_cmp
        assign match[g] = tbl_q.occ[g] && (tbl_q.addr[g] == lk_addr);
    end

    assign occ    = tbl_q.occ;
    assign lk_hit = |match;

    AST_SET_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |-> !occ[set_idx]);  // R4
    AST_CLR_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |-> occ[clr_idx]);   // R3
endmodule

// File: rtl/desc_flush_ctrl.sv
module desc_flush_ctrl
    import dcf_pkg::*;
#(
    parameter int NSLOT  = 4,
    parameter int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    output logic                cmd_ready,
    input  logic                cmd_unblock,
    input  logic [31:0]         cmd_word0,
    input  logic [31:0]         cmd_word1,
    output logic                fwd_req,
    output logic [ADDR_W-1:0]   fwd_addr,
    input  logic                fwd_done,
    output logic                flush_req,
    output logic [ADDR_W-1:0]   flush_addr,
    output logic                flush_all,
    output logic                flush_keep,
    input  logic                flush_done,
    output logic                sts_valid,
    output logic [1:0]          sts_code,
    input  logic [ADDR_W-1:0]   lk_addr,
    output logic                lk_blocked
);
    typedef struct packed {
        st_e                st;
        logic [ADDR_W-1:0]  addr;
        logic [SLOT_W-1:0]  idx;
        logic               blk;
        logic               keep;
        logic               all;
        logic               locked;
        logic               sts_v;
        sts_e               sts;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [ADDR_W-1:0] dec_addr;
    logic              dec_fwd, dec_rel, dec_keep, dec_blk, dec_all, dec_rsvd;
    logic [SLOT_W-1:0] dec_idx;
    logic              clr_en, set_en, lk_hit;
    logic [SLOT_W-1:0] clr_idx;
    logic [NSLOT-1:0]  occ;

    dcf_cmd_decode #(.SLOT_W(SLOT_W)) i_dec (
        .word0    (cmd_word0),
        .word1    (cmd_word1),
        .addr     (dec_addr),
        .fwd      (dec_fwd),
        .rel      (dec_rel),
        .idx      (dec_idx),
        .keep     (dec_keep),
        .blk      (dec_blk),
        .all      (dec_all),
        .rsvd_bad (dec_rsvd)
    );

    dcf_slot_table #(.NSLOT(NSLOT), .SLOT_W(SLOT_W)) i_slots (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_en   (clr_en),
        .clr_idx  (clr_idx),
        .set_en   (set_en),
        .set_idx  (ctl_q.idx),
        .set_addr (ctl_q.addr),
        .lk_addr  (lk_addr),
        .occ      (occ),
        .lk_hit   (lk_hit)
    );

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.sts_v = 1'b0;
        clr_en      = 1'b0;
        clr_idx     = dec_idx;
        set_en      = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    ctl_d.sts_v = 1'b1;
                    ctl_d.sts   = STS_OK;
                    if (!cmd_unblock) begin
                        if (dec_rsvd) begin
                            ctl_d.sts = STS_ILL;
                        end else if (dec_all) begin
                            ctl_d.sts_v = 1'b0;
                            ctl_d.addr  = dec_addr;
                            ctl_d.all   = 1'b1;
                            ctl_d.keep  = 1'b0;
                            ctl_d.blk   = 1'b0;
                            ctl_d.st    = ST_FLUSH;
                        end else if (dec_rel && !occ[dec_idx]) begin
                            ctl_d.sts = STS_RES;
                        end else if (dec_blk && !dec_rel && occ[dec_idx]) begin
                            ctl_d.sts = STS_RES;
                        end else begin
                            clr_en      = dec_rel;
                            ctl_d.sts_v = 1'b0;
                            ctl_d.addr  = dec_addr;
                            ctl_d.idx   = dec_idx;
                            ctl_d.all   = 1'b0;
                            ctl_d.keep  = dec_keep;
                            ctl_d.blk   = dec_blk;
                            ctl_d.st    = dec_fwd ? ST_FWD : ST_FLUSH;
                        end
                    end else if (dec_all) begin
                        if (ctl_q.locked) ctl_d.locked = 1'b0;
                        else              ctl_d.sts    = STS_RES;
                    end else begin
                        if (occ[dec_idx]) clr_en    = 1'b1;
                        else              ctl_d.sts = STS_RES;
                    end
                end
            end
            ST_FWD: begin
                if (fwd_done) ctl_d.st = ST_FLUSH;
            end
            ST_FLUSH: begin
                if (flush_done) begin
                    ctl_d.st    = ST_IDLE;
                    ctl_d.sts_v = 1'b1;
                    ctl_d.sts   = STS_OK;
                    if (ctl_q.all)      ctl_d.locked = 1'b1;
                    else if (ctl_q.blk) set_en       = 1'b1;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q     <= '0;
            ctl_q.st  <= ST_IDLE;
            ctl_q.sts <= STS_OK;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign cmd_ready  = (ctl_q.st == ST_IDLE);
    assign fwd_req    = (ctl_q.st == ST_FWD);
    assign flush_req  = (ctl_q.st == ST_FLUSH);
    assign fwd_addr   = ctl_q.addr;
    assign flush_addr = ctl_q.addr;
    assign flush_all  = ctl_q.all;
    assign flush_keep = ctl_q.keep;
    assign sts_valid  = ctl_q.sts_v;
    assign sts_code   = ctl_q.sts;
    assign lk_blocked = ctl_q.locked | lk_hit;

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((fwd_req || flush_req) && $past(fwd_req || flush_req)) |-> $stable(flush_addr));  // R1
    AST_DONE_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flush_req) |-> (sts_valid && sts_code == STS_OK));  // R12
    AST_LOCK_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_q.locked) |-> $past(flush_req && flush_done && flush_all));  // R8
    AST_ERR_NO_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_valid && sts_code != STS_OK) |-> (!flush_req && !fwd_req));  // R3
endmodule

// File: tb/test_desc_flush_ctrl.sv
module test_desc_flush_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0, cmd_unblock = 1'b0;
    logic [31:0] cmd_word0 = '0, cmd_word1 = '0;
    logic        cmd_ready, fwd_req, flush_req, flush_all, flush_keep, sts_valid, lk_blocked;
    logic [39:0] fwd_addr, flush_addr;
    logic        fwd_done = 1'b0, flush_done = 1'b0;
    logic [1:0]  sts_code;
    logic [39:0] lk_addr = '0;

    always #2 clk = ~clk;

    desc_flush_ctrl i_desc_flush_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_unblock(cmd_unblock), .cmd_word0(cmd_word0), .cmd_word1(cmd_word1),
        .fwd_req(fwd_req), .fwd_addr(fwd_addr), .fwd_done(fwd_done),
        .flush_req(flush_req), .flush_addr(flush_addr), .flush_all(flush_all),
        .flush_keep(flush_keep), .flush_done(flush_done), .sts_valid(sts_valid),
        .sts_code(sts_code), .lk_addr(lk_addr), .lk_blocked(lk_blocked)
    );

    int n_chk = 0, n_err = 0;

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    typedef struct packed {
        logic        ub;
        logic [31:0] w0;
        logic [31:0] w1;
        logic [1:0]  code;
        logic        fwd;
        logic        fl;
        logic        all;
        logic        keep;
        logic [39:0] lk;
        logic        blk;
    } vec_t;

    // A=12_9ABCDEF0 B=AB_00001000 C=CD_55AA55AA
    localparam vec_t VEC [12] = '{
        '{1'b0, 32'h9ABCDEF0, 32'h00000012,                 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 40'h129ABCDEF0, 1'b0}, // R7
        '{1'b1, 32'h0,        32'h00000000,                 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 40'h129ABCDEF0, 1'b0}, // R9
        '{1'b0, 32'h00001000, 32'h000025AB,                 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 40'hAB00001000, 1'b1}, // R6
        '{1'b0, 32'h55AA55AA, 32'h000024CD,                 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 40'hCD55AA55AA, 1'b0}, // R4
        '{1'b0, 32'h55AA55AA, 32'h00000ACD,                 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 40'hAB00001000, 1'b1}, // R3
        '{1'b0, 32'h55AA55AA, 32'h001000CD,                 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 40'h2B00001000, 1'b0}, // R2 R11
        '{1'b0, 32'h55AA55AA, 32'h000036CD,                 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 40'hCD55AA55AA, 1'b1}, // R5
        '{1'b1, 32'h0,        32'h00004000,                 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 40'hCD55AA55AA, 1'b1}, // R10
        '{1'b0, 32'h77777777, 32'h00004B01,                 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 40'h0102030405, 1'b1}, // R8
        '{1'b1, 32'h0,        32'h00004000,                 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 40'h0102030405, 1'b0}, // R10
        '{1'b1, 32'h0,        32'h00000400,                 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 40'hCD55AA55AA, 1'b0}, // R9
        '{1'b1, 32'h0,        32'h00000400,                 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 40'hCD55AA55AA, 1'b0}  // R9
    };

    logic        seen_fwd, seen_fl, seen_sts, fl_all, fl_keep, order_bad, ready_bad;
    logic [39:0] fl_addr, fw_addr;
    logic [1:0]  got_code;

    task automatic run_cmd(input logic ub, input logic [31:0] w0, input logic [31:0] w1);
        int fcnt = 0, lcnt = 0;
        seen_fwd = 0; seen_fl = 0; seen_sts = 0; order_bad = 0; ready_bad = 0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_unblock = ub; cmd_word0 = w0; cmd_word1 = w1;
        @(posedge clk);
        #1 cmd_valid = 1'b0;
        for (int t = 0; t < 100 && !seen_sts; t++) begin
            @(negedge clk);
            fwd_done = 1'b0; flush_done = 1'b0;
            if (sts_valid) begin
                seen_sts = 1; got_code = sts_code;
            end else if (cmd_ready) begin
                ready_bad = ready_bad | seen_fwd | seen_fl;
            end
            if (fwd_req) begin
                if (cmd_ready) ready_bad = 1;
                seen_fwd = 1; fw_addr = fwd_addr;
                if (seen_fl) order_bad = 1;
                fcnt++;
                if (fcnt == 3) fwd_done = 1'b1;
            end
            if (flush_req) begin
                if (cmd_ready) ready_bad = 1;
                if (!seen_fl && seen_fwd && fcnt < 3) order_bad = 1;
                seen_fl = 1; fl_addr = flush_addr; fl_all = flush_all; fl_keep = flush_keep;
                lcnt++;
                if (lcnt == 2) flush_done = 1'b1;
            end
        end
        if (seen_sts) begin
            @(negedge clk);
            chk(!sts_valid, "R12 pulse width", sts_valid, 0);
        end
    endtask

    initial begin
        #200000;
        n_err++; n_chk++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        lk_addr = 40'h129ABCDEF0;
        #1;
        chk(cmd_ready === 1'b1, "R13 ready", cmd_ready, 1);
        chk(!fwd_req && !flush_req && !sts_valid, "R13 quiet", {fwd_req, flush_req, sts_valid}, 0);
        chk(lk_blocked === 1'b0, "R13 lookup", lk_blocked, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cmd_ready === 1'b1 && !sts_valid, "R13 after reset", {cmd_ready, sts_valid}, 2'b10);

        for (int i = 0; i < 12; i++) begin
            run_cmd(VEC[i].ub, VEC[i].w0, VEC[i].w1);
            chk(seen_sts && got_code == VEC[i].code, $sformatf("R12 code row %0d", i), {seen_sts, got_code}, {1'b1, VEC[i].code});
            chk(seen_fwd == VEC[i].fwd, $sformatf("R6 forward row %0d", i), seen_fwd, VEC[i].fwd);
            chk(seen_fl == VEC[i].fl, $sformatf("R2 R3 R4 flush issued row %0d", i), seen_fl, VEC[i].fl);
            chk(!order_bad, $sformatf("R6 order row %0d", i), order_bad, 0);
            chk(!ready_bad, $sformatf("R12 ready row %0d", i), ready_bad, 0);
            if (VEC[i].fl) begin
                chk(fl_addr == {VEC[i].w1[7:0], VEC[i].w0}, $sformatf("R1 flush addr row %0d", i), fl_addr, {VEC[i].w1[7:0], VEC[i].w0});
                chk(fl_all == VEC[i].all, $sformatf("R7 R8 all row %0d", i), fl_all, VEC[i].all);
                chk(fl_keep == VEC[i].keep, $sformatf("R7 keep row %0d", i), fl_keep, VEC[i].keep);
            end
            if (VEC[i].fwd)
                chk(fw_addr == {VEC[i].w1[7:0], VEC[i].w0}, $sformatf("R1 fwd addr row %0d", i), fw_addr, {VEC[i].w1[7:0], VEC[i].w0});
            lk_addr = VEC[i].lk;
            #1;
            chk(lk_blocked == VEC[i].blk, $sformatf("R11 lookup row %0d", i), lk_blocked, VEC[i].blk);
        end

        // R5: old address B released by the reblock in row 6
        lk_addr = 40'hAB00001000;
        #1;
        chk(lk_blocked == 1'b0, "R5 old address freed", lk_blocked, 0);

        // R11: bit 0 differs from a blocked slot address
        run_cmd(1'b0, 32'h00000010, 32'h00002C00);
        chk(got_code == 2'd0, "R11 block slot3", got_code, 0);
        lk_addr = 40'h0000000011;
        #1;
        chk(lk_blocked == 1'b0, "R11 bit0 mismatch", lk_blocked, 0);
        lk_addr = 40'h0000000010;
        #1;
        chk(lk_blocked == 1'b1, "R11 exact match", lk_blocked, 1);

        // R8: whole-cache flush leaves slot 3 intact, unblock then still blocked
        run_cmd(1'b0, 32'h0, 32'h00004000);
        run_cmd(1'b1, 32'h0, 32'h00004000);
        chk(got_code == 2'd0, "R10 unlock", got_code, 0);
        #1;
        chk(lk_blocked == 1'b1, "R8 slots unchanged", lk_blocked, 1);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule